// File: doc/BRIEF.md
# Rotating-Priority Interrupt Arbiter for Eight Serial Channels

Eight serial channels raise interrupt requests that are merged onto one shared, active-low request output. When the host runs an interrupt-select (acknowledge) cycle, the arbiter chooses one pending channel, holds it, and after a fixed number of wait states returns that channel's 8-bit vector with a one-cycle ready pulse and a one-hot indication of the channel served.

The choice is made by rotating priority. Out of reset channel 0 ranks highest and channel 7 lowest. Each completed service moves the channel just served to the bottom of the order, so the channel after it ranks highest next. A channel that keeps requesting therefore cannot lock the other channels out. The vector for each channel comes from a per-channel register supplied on a flat input bus.

Top module: `irq_rotor`

## Requirements
- R1: `irq_n_o` is low in any cycle in which at least one bit of `req_i` is high, and high when no bit is set.
- R2: After reset `rdy_o` is 0, `served_o` is 0 and `vec_o` is 0. The first service picks the lowest-numbered pending channel.
- R3: The winner is the first pending channel found when scanning upward from the channel after the last one served, wrapping from channel 7 to channel 0.
- R4: With all eight channels requesting continuously, successive services go to channels 0,1,...,7,0 in that order.
- R5: During a service, `vec_o` equals the winner's vector, which is bits [8k+7:8k] of `vec_i` for channel k, sampled in the cycle the acknowledge is accepted.
- R6: The acknowledge is accepted at the clock edge where `sel_i` is high while the arbiter is idle. `rdy_o` is high for exactly the one cycle that follows edge WAIT+1 after acceptance (WAIT=2 by default).
- R7: From acceptance through the ready cycle, `vec_o` and the chosen channel do not change, even if `req_i` or `vec_i` change.
- R8: If no request is pending when the acknowledge is accepted, the ready cycle returns vector 0 and `served_o`=0, and the rotation order is left unchanged.
- R9: `served_o` is one-hot, naming the winner, only in the ready cycle, and is zero in every other cycle.
- R10: Holding `sel_i` high after the ready cycle does not start another service. A new service needs `sel_i` to go low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request per channel, bit k = channel k |
| vec_i | input | 64 | Per-channel vector registers, channel k in bits [8k+7:8k] |
| sel_i | input | 1 | Host interrupt-select strobe, held until ready |
| irq_n_o | output | 1 | Shared active-low interrupt request |
| vec_o | output | 8 | Vector of the channel being served |
| rdy_o | output | 1 | One-cycle pulse that ends the select cycle |
| served_o | output | 8 | One-hot channel served, valid with `rdy_o` |

## Verification
Two functions can fall in the same cycle: the capture of a winner at acceptance, and changes to the requests and vector registers that would alter that choice. The bench provokes this by rewriting `req_i` and `vec_i` during every wait state. It judges the outcome by checking that `vec_o` and `served_o` still match the values predicted from the inputs at acceptance. A second overlap is the pointer update at the end of one service meeting a re-asserted strobe. The bench holds `sel_i` high through and beyond the ready cycle and checks that no second ready pulse appears.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2,
    ST_HOLD = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irq_rotor_pick.sv
module irq_rotor_pick #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  last,
  output logic [NCH-1:0] win_oh,
  output logic [IW-1:0]  win_idx,
  output logic           any
);
  // Scan upward from the channel after 'last', wrapping.
  function automatic logic [IW:0] next_after(input logic [NCH-1:0] r,
                                             input logic [IW-1:0] l);
    logic [IW:0] res;
    int          idx;
    res = '0;
    for (int off = NCH; off >= 1; off--) begin
      idx = int'(l) + off;
      if (idx >= NCH) idx = idx - NCH;
      if (r[idx]) res = {1'b1, IW'(idx)};
    end
    return res;
  endfunction

  logic [IW:0] found;

  always_comb begin
    found   = next_after(req, last);
    any     = found[IW];
    win_idx = found[IW-1:0];
    win_oh  = '0;
    if (any) win_oh[win_idx] = 1'b1;
  end
endmodule

// File: rtl/irq_rotor_vsel.sv
module irq_rotor_vsel #(
  parameter int NCH = 8,
  parameter int VW  = 8
) (
  input  logic [NCH*VW-1:0] vecs,
  input  logic [NCH-1:0]    sel_oh,
  output logic [VW-1:0]     vec
);
  logic [VW-1:0] masked [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_mask
    assign masked[ch] = sel_oh[ch] ? vecs[ch*VW +: VW] : '0;
  end

  always_comb begin
    vec = '0;
    for (int ch = 0; ch < NCH; ch++) vec = vec | masked[ch];
  end
endmodule

// File: rtl/irq_rotor_seq.sv
module irq_rotor_seq
  import irq_rotor_pkg::*;
#(
  parameter int WAIT = 2,
  localparam int CW = $clog2(WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic start,
  output logic busy,
  output logic done
);
  ack_state_e    st_q;
  logic [CW-1:0] wcnt_q;

  assign start = (st_q == ST_IDLE) && sel;
  assign busy  = (st_q == ST_WAIT) || (st_q == ST_DONE);
  assign done  = (st_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (sel) begin
          st_q   <= ST_WAIT;
          wcnt_q <= '0;
        end
        ST_WAIT: begin
          if (wcnt_q == CW'(WAIT - 1)) st_q <= ST_DONE;
          else wcnt_q <= wcnt_q + 1'b1;
        end
        ST_DONE: st_q <= ST_HOLD;
        default: if (!sel) st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_rotor.sv
module irq_rotor #(
  parameter int NCH  = 8,
  parameter int VW   = 8,
  parameter int WAIT = 2,
  localparam int IW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*VW-1:0] vec_i,
  input  logic              sel_i,
  output logic              irq_n_o,
  output logic [VW-1:0]     vec_o,
  output logic              rdy_o,
  output logic [NCH-1:0]    served_o
);
  logic [IW-1:0]  last_q;
  logic [NCH-1:0] pick_oh;
  logic [IW-1:0]  pick_idx;
  logic           pick_any;
  logic [VW-1:0]  pick_vec;
  logic           seq_start, seq_busy, seq_done;
  logic [NCH-1:0] win_oh_q;
  logic [IW-1:0]  win_idx_q;
  logic           any_q;
  logic [VW-1:0]  vec_q;

  irq_rotor_pick #(.NCH(NCH)) u_pick (
    .req(req_i), .last(last_q),
    .win_oh(pick_oh), .win_idx(pick_idx), .any(pick_any)
  );

  irq_rotor_vsel #(.NCH(NCH), .VW(VW)) u_vsel (
    .vecs(vec_i), .sel_oh(pick_oh), .vec(pick_vec)
  );

  irq_rotor_seq #(.WAIT(WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel(sel_i),
    .start(seq_start), .busy(seq_busy), .done(seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_oh_q  <= '0;
      win_idx_q <= '0;
      any_q     <= 1'b0;
      vec_q     <= '0;
      last_q    <= IW'(NCH - 1);
    end else begin
      if (seq_start) begin
        win_oh_q  <= pick_oh;
        win_idx_q <= pick_idx;
        any_q     <= pick_any;
        vec_q     <= pick_vec;
      end
      if (seq_done && any_q) last_q <= win_idx_q;
    end
  end

  assign irq_n_o  = ~|req_i;
  assign vec_o    = seq_busy ? vec_q : '0;
  assign rdy_o    = seq_done;
  assign served_o = seq_done ? win_oh_q : '0;
endmodule

// File: rtl/irq_rotor_chk.sv
module irq_rotor_chk #(
  parameter int NCH  = 8,
  parameter int VW   = 8,
  parameter int WAIT = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           any_q,
  input logic           rdy_o,
  input logic [VW-1:0]  vec_o,
  input logic [NCH-1:0] served_o
);
  int unsigned since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= 0;
    else if (start) since_q <= 1;
    else if (rdy_o) since_q <= 0;
    else if (since_q != 0) since_q <= since_q + 1;
  end

  assert_rdy_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> since_q == WAIT + 1);

  assert_rdy_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  assert_vec_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vec_o));

  assert_served_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(served_o) && (served_o != '0 -> rdy_o));

  assert_empty_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !any_q) |-> (served_o == '0 && vec_o == '0));
endmodule

bind irq_rotor irq_rotor_chk #(.NCH(NCH), .VW(VW), .WAIT(WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(seq_start), .busy(seq_busy),
  .any_q(any_q), .rdy_o(rdy_o), .vec_o(vec_o), .served_o(served_o)
);

// File: tb/test_irq_rotor.sv
module test_irq_rotor;
  localparam int NCH = 8, VW = 8, WAIT = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    req_i = '0;
  logic [NCH*VW-1:0] vec_i = '0;
  logic              sel_i = 1'b0;
  logic              irq_n_o, rdy_o;
  logic [VW-1:0]     vec_o;
  logic [NCH-1:0]    served_o;

  int n_run = 0, n_fail = 0;
  int last_m = NCH - 1;

  irq_rotor #(.NCH(NCH), .VW(VW), .WAIT(WAIT)) i_irq_rotor (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .vec_i(vec_i), .sel_i(sel_i),
    .irq_n_o(irq_n_o), .vec_o(vec_o), .rdy_o(rdy_o), .served_o(served_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Rotate the request word so the slot after last_m sits at bit 0, then take the lowest set bit.
  function automatic int model_pick(input logic [NCH-1:0] r, input int last);
    logic [2*NCH-1:0] dbl;
    logic [NCH-1:0]   rot;
    dbl = {r, r};
    rot = dbl[(last + 1) % NCH +: NCH];
    for (int k = 0; k < NCH; k++)
      if (rot[k]) return (last + 1 + k) % NCH;
    return -1;
  endfunction

  // One complete select cycle with disturbance in the wait states.
  task automatic do_ack(input bit disturb);
    int       w;
    int       got;
    logic [VW-1:0] ev;
    logic [NCH-1:0] es;
    w  = model_pick(req_i, last_m);
    ev = (w < 0) ? '0 : vec_i[w*VW +: VW];
    es = (w < 0) ? '0 : (NCH'(1) << w);
    @(negedge clk) sel_i = 1'b1;
    got = 0;
    for (int n = 1; n <= WAIT + 3; n++) begin
      @(negedge clk);
      if (rdy_o && got == 0) got = n;
      if (n <= WAIT) begin
        chk(vec_o == ev, "R7 vec held in wait", vec_o, ev);
        chk(served_o == '0, "R9 served idle in wait", served_o, 0);
        if (disturb) begin
          req_i = NCH'($urandom);
          vec_i = {$urandom, $urandom};
        end
      end
      if (n == WAIT + 1) begin
        chk(rdy_o == 1'b1, "R6 ready timing", rdy_o, 1);
        chk(vec_o == ev, "R5 vec value", vec_o, ev);
        chk(served_o == es, (w < 0) ? "R8 empty served" : "R3 served winner", served_o, es);
        sel_i = 1'b0;
      end
      if (n > WAIT + 1) chk(rdy_o == 1'b0, "R6 single pulse", rdy_o, 0);
    end
    if (w >= 0) last_m = w;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy_o == 0 && served_o == 0 && vec_o == 0, "R2 reset outputs",
        {rdy_o, served_o, vec_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_n_o == 1'b1, "R1 idle line high", irq_n_o, 1);

    for (int c = 0; c < NCH; c++) vec_i[c*VW +: VW] = VW'(8'hA0 + c);

    // R2: first service goes to the lowest pending channel
    req_i = 8'b0110_0100;
    #1 chk(irq_n_o == 1'b0, "R1 line low", irq_n_o, 0);
    do_ack(1'b0);

    // R4: all requesting, order 3,4,..,7,0,1,2,3 after the service of channel 2
    for (int i = 0; i < NCH + 1; i++) begin
      req_i = '1;
      do_ack(1'b0);
      chk(last_m == (3 + i) % NCH, "R4 rotation order", last_m, (3 + i) % NCH);
    end

    // R8: empty acknowledge leaves the order unchanged
    req_i = '0;
    do_ack(1'b0);
    req_i = '1;
    do_ack(1'b0);
    chk(last_m == 4, "R8 order kept", last_m, 4);

    // R10: strobe held after ready does not retrigger
    @(negedge clk) sel_i = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (n > WAIT + 1) chk(rdy_o == 1'b0, "R10 no retrigger", rdy_o, 0);
    end
    last_m = 5;
    sel_i = 1'b0;
    repeat (2) @(negedge clk);

    // Random mix with disturbance during wait states (R3, R5, R7)
    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      req_i = NCH'($urandom);
      vec_i = {$urandom, $urandom};
      #1 chk(irq_n_o == (req_i == '0), "R1 random line", irq_n_o, req_i == '0);
      do_ack(1'b1);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule